// File: doc/BRIEF.md
# Frame and Multiframe Sync Generator

This block divides a fast output clock down to two periodic sync pulses. One is a frame pulse that repeats every `frame_div` clock cycles, which is 8 kHz when the clock is `frame_div` times 8 kHz. The other is a multiframe pulse that marks every fourth frame, which gives 2 kHz. Both pulses are registered on the output clock, so their edges line up with that clock's edges. Each pulse has its own polarity control and its own width in clock cycles.

An external frame reference at 8, 4 or 2 kHz can re-phase the counters when discipline is on. A rising edge of that reference restarts the frame count. If the reference is selected as 2 kHz, the same edge also restarts the multiframe count. The reference is taken to be synchronous to the output clock already. The clock synthesis ahead of this block is outside its scope.

Top module: `frame_sync_gen`

## Requirements
- R1: The multiframe pulse appears only in frame index 0 of each group of four frames. It starts on the same clock edge as that frame's frame pulse and lasts max(`mfp_width`,1) cycles.
- R2: With `en` high, the frame pulse starts every `frame_div` clock cycles (`frame_div` >= 2).
- R3: A polarity input of 0 gives an active-high output. A polarity input of 1 gives an active-low output. Polarity acts on the output combinationally.
- R4: A pulse stays active for max(width,1) clock cycles, counted from its first active cycle. A width of 0 gives a one-cycle pulse.
- R5: The outputs sit at their inactive level (equal to the polarity input) in the cycles that follow a clock edge with `rst_n` low or with `en` low.
- R6: `ext_sync` is sampled on every clock edge. When `disc_en` is high and a sample of 1 follows a sample of 0, that edge starts a new frame at once. For `ext_rate` codes 0 (8 kHz), 1 (4 kHz) and 3 (treated as 8 kHz), the multiframe index moves on by one, wrapping 3 to 0. For code 2 (2 kHz), the multiframe index goes to 0 and a multiframe pulse begins.
- R7: With `disc_en` low, `ext_sync` has no effect on either output.
- R8: The first clock edge with `en` high after `en` was low starts frame 0 of a multiframe. Both pulses begin on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-rate output clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable; low holds the counters at the pre-start point |
| frame_div | input | DIV_W | Clock cycles per frame |
| ext_sync | input | 1 | External frame reference, synchronous to clk |
| ext_rate | input | 2 | Reference rate code: 0 = 8 kHz, 1 = 4 kHz, 2 = 2 kHz, 3 = 8 kHz |
| disc_en | input | 1 | Enables re-phasing by ext_sync |
| fp_pol | input | 1 | Frame pulse polarity (1 = active low) |
| mfp_pol | input | 1 | Multiframe pulse polarity (1 = active low) |
| fp_width | input | WID_W | Frame pulse width in cycles |
| mfp_width | input | WID_W | Multiframe pulse width in cycles |
| fp_out | output | 1 | Frame sync pulse |
| mfp_out | output | 1 | Multiframe sync pulse |

## Verification
The assertions assume that the widths hold steady while they are checked. They also assume that `ext_sync` is already in the clock domain and that `frame_div` is at least 2 and does not change while `en` is high. The stimulus changes `frame_div` only with `en` low and changes inputs only on falling edges. It keeps widths constant within each sweep point and drives `ext_sync` as clean multi-cycle levels. The sweep covers several divisors, width pairs that include zero and the full frame, and all four polarity combinations. Every rate code is exercised with discipline on and with discipline off.

// File: rtl/fsync_pkg.sv
`timescale 1ns/1ps
// Package: shared encodings for the frame sync generator.
// Assumes nothing beyond a four-frame multiframe.
package fsync_pkg;
    typedef enum logic [1:0] {
        RATE_8K  = 2'd0,
        RATE_4K  = 2'd1,
        RATE_2K  = 2'd2,
        RATE_ALT = 2'd3
    } ext_rate_e;

    localparam int FRAMES_PER_MF = 4;
endpackage

// File: rtl/fsync_edge_det.sv
`timescale 1ns/1ps
// Rising-edge detector for the external frame reference.
// Assumes the input is already synchronous to clk; flags a 1 sample after a 0 sample.
module fsync_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o
);
    logic prev_q;

    // Keep the previous sample of the reference.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sig_i;
    end

    assign rise_o = sig_i & ~prev_q;
endmodule

// File: rtl/fsync_frame_ctr.sv
`timescale 1ns/1ps
// Frame and multiframe counters.
// Presents next-state values so that the registered pulses line up with the counter state.
// While disabled, the counters sit at the last cycle of the last frame,
// so the first enabled edge opens frame 0. Assumes frame_div >= 2.
module fsync_frame_ctr #(
    parameter int DIV_W  = 17,
    parameter int MF_LEN = 4,
    localparam int MF_W  = (MF_LEN > 1) ? $clog2(MF_LEN) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] frame_div,
    input  logic             reload,
    input  logic             mf_reload,
    output logic [DIV_W-1:0] fcnt_nx,
    output logic [MF_W-1:0]  mcnt_nx
);
    localparam logic [MF_W-1:0] MF_LAST = MF_W'(MF_LEN - 1);

    logic [DIV_W-1:0] fcnt;
    logic [MF_W-1:0]  mcnt;
    logic [DIV_W-1:0] last_cnt;
    logic             wrap;

    // Next-state logic: wrap, re-phase or count.
    always_comb begin
        last_cnt = frame_div - DIV_W'(1);
        wrap     = (fcnt >= last_cnt);
        if (!en) begin
            fcnt_nx = last_cnt;
            mcnt_nx = MF_LAST;
        end else begin
            fcnt_nx = (wrap || reload) ? '0 : fcnt + DIV_W'(1);
            if (mf_reload)
                mcnt_nx = '0;
            else if (wrap || reload)
                mcnt_nx = (mcnt == MF_LAST) ? '0 : mcnt + MF_W'(1);
            else
                mcnt_nx = mcnt;
        end
    end

    // Counter state registers; reset leaves them at the pre-start point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fcnt <= '1;
            mcnt <= MF_LAST;
        end else begin
            fcnt <= fcnt_nx;
            mcnt <= mcnt_nx;
        end
    end
endmodule

// File: rtl/fsync_pulse_shaper.sv
`timescale 1ns/1ps
// Width and polarity stage for one sync output.
// Registers "active" from the next counter value, which keeps the edges on clk.
// A width of zero counts as one cycle. Polarity is applied after the register.
module fsync_pulse_shaper #(
    parameter int CNT_W = 17,
    parameter int WID_W = 8,
    localparam int CMP_W = ((CNT_W > WID_W) ? CNT_W : WID_W) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             gate,
    input  logic [CNT_W-1:0] cnt_nx,
    input  logic [WID_W-1:0] width,
    input  logic             pol,
    output logic             pulse_o
);
    logic [CMP_W-1:0] width_eff;
    logic             hit;
    logic             act_q;

    // Effective width and the in-window test.
    always_comb begin
        width_eff = (width == '0) ? CMP_W'(1) : CMP_W'(width);
        hit       = gate && (CMP_W'(cnt_nx) < width_eff);
    end

    // Active-state register, cleared in reset and while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= 1'b0;
        else        act_q <= en && hit;
    end

    assign pulse_o = act_q ^ pol;
endmodule

// File: rtl/frame_sync_gen.sv
`timescale 1ns/1ps
// Top: frame (every frame_div cycles) and multiframe (every fourth frame) sync pulses.
// Assumes ext_sync is synchronous to clk and that frame_div >= 2 stays steady while en is high.
module frame_sync_gen #(
    parameter int DIV_W = 17,
    parameter int WID_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] frame_div,
    input  logic             ext_sync,
    input  logic [1:0]       ext_rate,
    input  logic             disc_en,
    input  logic             fp_pol,
    input  logic             mfp_pol,
    input  logic [WID_W-1:0] fp_width,
    input  logic [WID_W-1:0] mfp_width,
    output logic             fp_out,
    output logic             mfp_out
);
    import fsync_pkg::*;

    localparam int MF_W    = $clog2(FRAMES_PER_MF);
    localparam int N_PULSE = 2;

    logic             ext_rise;
    logic             reload;
    logic             mf_reload;
    logic [DIV_W-1:0] fcnt_nx;
    logic [MF_W-1:0]  mcnt_nx;
    logic [N_PULSE-1:0] gate_v;
    logic [N_PULSE-1:0] pol_v;
    logic [N_PULSE-1:0] out_v;
    logic [WID_W-1:0]   wid_v [N_PULSE];

    fsync_edge_det u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (ext_sync),
        .rise_o (ext_rise)
    );

    // Discipline decode: frame restart, plus multiframe restart at 2 kHz.
    always_comb begin
        reload    = disc_en && ext_rise;
        mf_reload = reload && (ext_rate_e'(ext_rate) == RATE_2K);
    end

    fsync_frame_ctr #(
        .DIV_W  (DIV_W),
        .MF_LEN (FRAMES_PER_MF)
    ) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .frame_div (frame_div),
        .reload    (reload),
        .mf_reload (mf_reload),
        .fcnt_nx   (fcnt_nx),
        .mcnt_nx   (mcnt_nx)
    );

    // Per-output selection: index 0 is the frame pulse, index 1 the multiframe pulse.
    always_comb begin
        gate_v[0] = 1'b1;
        gate_v[1] = (mcnt_nx == '0);
        pol_v[0]  = fp_pol;
        pol_v[1]  = mfp_pol;
        wid_v[0]  = fp_width;
        wid_v[1]  = mfp_width;
    end

    for (genvar gi = 0; gi < N_PULSE; gi++) begin : g_pulse
        fsync_pulse_shaper #(
            .CNT_W (DIV_W),
            .WID_W (WID_W)
        ) u_shp (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (en),
            .gate    (gate_v[gi]),
            .cnt_nx  (fcnt_nx),
            .width   (wid_v[gi]),
            .pol     (pol_v[gi]),
            .pulse_o (out_v[gi])
        );
    end

    assign fp_out  = out_v[0];
    assign mfp_out = out_v[1];
endmodule

// File: rtl/frame_sync_gen_chk.sv
`timescale 1ns/1ps
// Checker for frame_sync_gen. It watches only the top-level ports.
// Assumes the widths are held steady while they are compared.
module frame_sync_gen_chk #(
    parameter int WID_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             ext_sync,
    input logic [1:0]       ext_rate,
    input logic             disc_en,
    input logic             fp_pol,
    input logic             mfp_pol,
    input logic [WID_W-1:0] fp_width,
    input logic [WID_W-1:0] mfp_width,
    input logic             fp_out,
    input logic             mfp_out
);
    logic en_q, en_qq, ext_q, rel_q, rel2k_q;
    logic fp_act, mfp_act;
    logic [WID_W:0] fw_eff, mw_eff;

    // Local history of enable and the reference, independent of the design.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            en_qq   <= 1'b0;
            ext_q   <= 1'b0;
            rel_q   <= 1'b0;
            rel2k_q <= 1'b0;
        end else begin
            en_q    <= en;
            en_qq   <= en_q;
            ext_q   <= ext_sync;
            rel_q   <= en && disc_en && ext_sync && !ext_q;
            rel2k_q <= en && disc_en && ext_sync && !ext_q && (ext_rate == 2'd2);
        end
    end

    // Active-level view of the outputs and effective widths.
    always_comb begin
        fp_act  = fp_out ^ fp_pol;
        mfp_act = mfp_out ^ mfp_pol;
        fw_eff  = (fp_width == '0)  ? (WID_W+1)'(1) : (WID_W+1)'(fp_width);
        mw_eff  = (mfp_width == '0) ? (WID_W+1)'(1) : (WID_W+1)'(mfp_width);
    end

    AST_IDLE_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!fp_act && !mfp_act)); // R5

    AST_START_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !en_qq) |-> (fp_act && mfp_act)); // R8

    AST_MF_INSIDE_FP: assert property (@(posedge clk) disable iff (!rst_n)
        (mfp_act && $stable(fp_width) && $stable(mfp_width) && (mw_eff <= fw_eff)) |-> fp_act); // R1

    AST_RELOAD_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        rel_q |-> fp_act); // R6

    AST_RELOAD_MFRAME: assert property (@(posedge clk) disable iff (!rst_n)
        rel2k_q |-> mfp_act); // R6
endmodule

bind frame_sync_gen frame_sync_gen_chk #(.WID_W(WID_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .ext_sync  (ext_sync),
    .ext_rate  (ext_rate),
    .disc_en   (disc_en),
    .fp_pol    (fp_pol),
    .mfp_pol   (mfp_pol),
    .fp_width  (fp_width),
    .mfp_width (mfp_width),
    .fp_out    (fp_out),
    .mfp_out   (mfp_out)
);

// File: tb/frame_sync_gen_tb_top.sv
`timescale 1ns/1ps
// Sweep bench for frame_sync_gen; a cycle model derived from the requirements gives the expected outputs.
module frame_sync_gen_tb_top;
    localparam int DIV_W = 6;
    localparam int WID_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b0;
    logic [DIV_W-1:0] frame_div = DIV_W'(4);
    logic             ext_sync = 1'b0;
    logic [1:0]       ext_rate = 2'd0;
    logic             disc_en = 1'b0;
    logic             fp_pol = 1'b0;
    logic             mfp_pol = 1'b0;
    logic [WID_W-1:0] fp_width = '0;
    logic [WID_W-1:0] mfp_width = '0;
    logic             fp_out, mfp_out;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    int m_p = 0;
    int m_fr = 3;
    bit m_val = 0;
    bit m_prev = 0;

    always #5 clk = ~clk;

    frame_sync_gen #(.DIV_W(DIV_W), .WID_W(WID_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .frame_div(frame_div),
        .ext_sync(ext_sync), .ext_rate(ext_rate), .disc_en(disc_en),
        .fp_pol(fp_pol), .mfp_pol(mfp_pol), .fp_width(fp_width),
        .mfp_width(mfp_width), .fp_out(fp_out), .mfp_out(mfp_out)
    );

    function automatic int weff(input int w);
        return (w == 0) ? 1 : w;
    endfunction

    // Advance the model with the inputs the design samples, clock once, then compare.
    task automatic tick(input string tag);
        bit rel, wrap, e_fp, e_mfp;
        int d;
        d = int'(frame_div);
        if (!rst_n) begin
            m_p = d - 1; m_fr = 3; m_val = 0; m_prev = 0;
        end else begin
            rel = disc_en && ext_sync && !m_prev;
            m_prev = ext_sync;
            if (!en) begin
                m_p = d - 1; m_fr = 3; m_val = 0;
            end else begin
                wrap = (m_p >= d - 1);
                m_p = (wrap || rel) ? 0 : m_p + 1;
                if (rel && ext_rate == 2'd2) m_fr = 0;
                else if (wrap || rel)        m_fr = (m_fr + 1) % 4;
                m_val = 1;
            end
        end
        @(posedge clk);
        @(negedge clk);
        e_fp  = fp_pol  ^ (m_val && m_p < weff(int'(fp_width)));
        e_mfp = mfp_pol ^ (m_val && m_fr == 0 && m_p < weff(int'(mfp_width)));
        checks++;
        if (fp_out !== e_fp) begin
            fails++;
            $display("FAIL %s fp_out actual=%b expected=%b (p=%0d)", tag, fp_out, e_fp, m_p);
        end
        checks++;
        if (mfp_out !== e_mfp) begin
            fails++;
            $display("FAIL %s mfp_out actual=%b expected=%b (frame=%0d p=%0d)", tag, mfp_out, e_mfp, m_fr, m_p);
        end
    endtask

    initial begin : watchdog
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        int divs [3] = '{4, 5, 8};
        int fws  [4] = '{0, 1, 2, 3};
        int mws  [2] = '{0, 2};
        int gaps [4] = '{3, 9, 14, 7};

        @(negedge clk);
        // R5: reset state under both polarities
        fp_pol = 1'b1; mfp_pol = 1'b0; en = 1'b1;
        for (int i = 0; i < 3; i++) tick("R5 reset");
        fp_pol = 1'b0; mfp_pol = 1'b1;
        for (int i = 0; i < 2; i++) tick("R5 reset");
        rst_n = 1'b1; en = 1'b0;

        // R1 R2 R3 R4 R8: sweep of divisor, widths and polarities
        foreach (divs[di]) foreach (fws[fi]) foreach (mws[mi])
            for (int pc = 0; pc < 4; pc++) begin
                en = 1'b0;
                frame_div = DIV_W'(divs[di]);
                fp_width  = WID_W'(fws[fi]);
                mfp_width = WID_W'(mws[mi]);
                fp_pol  = pc[0];
                mfp_pol = pc[1];
                for (int i = 0; i < 2; i++) tick("R5 disabled");
                en = 1'b1;
                for (int i = 0; i < 8 * divs[di] + 3; i++) tick("R1 R2 R3 R4 R8 sweep");
            end

        // Full-frame width: the frame pulse never drops (R4)
        en = 1'b0; frame_div = DIV_W'(5); fp_width = WID_W'(5); mfp_width = WID_W'(5);
        fp_pol = 1'b0; mfp_pol = 1'b0;
        tick("R5 disabled");
        en = 1'b1;
        for (int i = 0; i < 25; i++) tick("R4 full width");

        // R6 with discipline on for each rate code; R7 with it off
        for (int dis = 1; dis >= 0; dis--)
            for (int rc = 0; rc < 4; rc++) begin
                en = 1'b0; disc_en = dis[0]; ext_rate = rc[1:0];
                frame_div = DIV_W'(6); fp_width = WID_W'(2); mfp_width = WID_W'(3);
                fp_pol = rc[0]; mfp_pol = rc[1];
                tick(dis ? "R6 disabled" : "R7 disabled");
                en = 1'b1;
                foreach (gaps[gi]) begin
                    for (int i = 0; i < gaps[gi]; i++) tick(dis ? "R6 wait" : "R7 wait");
                    ext_sync = 1'b1;
                    for (int i = 0; i < 2; i++) tick(dis ? "R6 edge" : "R7 edge");
                    ext_sync = 1'b0;
                end
                for (int i = 0; i < 30; i++) tick(dis ? "R6 after" : "R7 after");
            end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule